// File: doc/BRIEF.md
# CRC-32 Checksum Accelerator

This block computes a 32-bit cyclic redundancy check for software. It sits behind an APB3 slave port with an 8-bit address and 32-bit data. Software restarts a checksum by writing the restart register. It then writes data words one at a time and reads the checksum back. Each data write folds a whole 32-bit word into the CRC state within the clock edge that completes the write, so the new checksum can be read by the very next access. There is no input queue.

The polynomial variant, the bit reversal of input words, the bit reversal of the presented state and the presence of a writable final-XOR register are all fixed when the design is built. A read-only configuration register lets software find out which options were built in. Two variants are available. ISO-HDLC (the Ethernet/zlib CRC) uses polynomial 0x04C11DB7 with initial value and final XOR both 0xFFFFFFFF. XFER uses polynomial 0x000000AF with initial value and final XOR both 0.

Top module: `crc32_apb_accel`

## Requirements
- R1: Every APB3 access, read or write, completes with pready_o high and pslverr_o low, so there are no wait states.
- R2: After reset the CRC state holds the variant's initial value. With the default build (ISO-HDLC, both reflections on, no XOR register), the checksum register at 0x14 therefore reads 0x00000000 before any data is written.
- R3: A write to the data register at 0x10 folds the full 32-bit word into the state in one cycle, and the next access can read the updated checksum. With the default build, the single word 0x64636261 gives 0xED82CD11. The state does not change in cycles without a data or restart write.
- R4: With the default build, a sequence of data words gives the standard reflected CRC-32 of their bytes, with each word's least-significant byte fed first.
- R5: A write of any value to the restart register at 0x0C reloads the initial value into the state.
- R6: The configuration register at 0x08 reads as follows. Bits 7:0 hold 32. Bit 8 is the input-reversal flag, bit 9 the output-reversal flag and bit 10 the XOR-register-present flag. All other bits read 0.
- R7: When the XOR register is built in, offset 0x18 is read/write and resets to the variant's standard final XOR (0xFFFFFFFF for ISO-HDLC). The checksum reads as the presented state XOR that register.
- R8: When the XOR register is not built in, 0x18 reads 0 and writes to it change neither that read nor the checksum. The variant's fixed standard final XOR is applied instead.
- R9: Reads of the write-only offsets 0x0C and 0x10, and of any unmapped offset, return 0.
- R10: An XFER build with both reflections off processes each word most-significant bit first, from initial value 0 with final XOR 0. Its checksum reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB3 slave select |
| penable_i | input | 1 | APB3 access phase |
| pwrite_i | input | 1 | APB3 write (1) or read (0) |
| paddr_i | input | ADDR_W | APB3 byte address |
| pwdata_i | input | 32 | APB3 write data |
| prdata_o | output | 32 | APB3 read data |
| pready_o | output | 1 | APB3 ready, always high |
| pslverr_o | output | 1 | APB3 error, always low |

## Verification
Some rules are checked by properties on every cycle. These are: the state holds when no data or restart write happens, a restart lands the initial value, the XOR register holds between writes, the configuration read layout, and zero data on unmapped, write-only or absent-register reads. Only the bench scenarios can show that the checksum values are correct. Those scenarios cover the known single-word result, multi-word streams against a byte-wise reference model, the XFER variant and the effect of a rewritten final XOR. The same goes for one-cycle visibility of a data write to the next read and for ignored writes to an absent XOR register.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

  typedef enum logic [0:0] {
    CRC_ISO_HDLC = 1'b0,
    CRC_XFER     = 1'b1
  } crc_variant_e;

  localparam logic [7:0] OFF_INFO   = 8'h08;
  localparam logic [7:0] OFF_CTRL   = 8'h0C;
  localparam logic [7:0] OFF_DATA   = 8'h10;
  localparam logic [7:0] OFF_RESULT = 8'h14;
  localparam logic [7:0] OFF_XOR    = 8'h18;

  localparam int unsigned CRC_W = 32;

  function automatic logic [CRC_W-1:0] poly_of(crc_variant_e v);
    return (v == CRC_XFER) ? 32'h0000_00AF : 32'h04C1_1DB7;
  endfunction

  function automatic logic [CRC_W-1:0] init_of(crc_variant_e v);
    return (v == CRC_XFER) ? 32'h0000_0000 : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [CRC_W-1:0] xorout_of(crc_variant_e v);
    return (v == CRC_XFER) ? 32'h0000_0000 : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [CRC_W-1:0] reflect32(logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  // Unrolled MSB-first fold of one word; synthesizes to an XOR network.
  function automatic logic [CRC_W-1:0] crc_fold(logic [CRC_W-1:0] state,
                                                 logic [CRC_W-1:0] word,
                                                 logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = state;
    for (int i = CRC_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ word[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    return c;
  endfunction

endpackage

// File: rtl/crc32_apb_port.sv
module crc32_apb_port #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  output logic              ctrl_we_o,
  output logic              data_we_o,
  output logic              xor_we_o,
  output logic              rd_info_o,
  output logic              rd_result_o,
  output logic              rd_xor_o,
  output logic              pready_o,
  output logic              pslverr_o
);
  import crc32_pkg::*;

  localparam logic [ADDR_W-1:0] A_INFO   = ADDR_W'(OFF_INFO);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_RESULT = ADDR_W'(OFF_RESULT);
  localparam logic [ADDR_W-1:0] A_XOR    = ADDR_W'(OFF_XOR);

  logic access, wr, rd;

  assign access = psel_i & penable_i;
  assign wr     = access & pwrite_i;
  assign rd     = access & ~pwrite_i;

  assign ctrl_we_o   = wr & (paddr_i == A_CTRL);
  assign data_we_o   = wr & (paddr_i == A_DATA);
  assign xor_we_o    = wr & (paddr_i == A_XOR);
  assign rd_info_o   = rd & (paddr_i == A_INFO);
  assign rd_result_o = rd & (paddr_i == A_RESULT);
  assign rd_xor_o    = rd & (paddr_i == A_XOR);

  // zero wait states, never an error
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

endmodule

// File: rtl/crc32_engine.sv
module crc32_engine #(
  parameter crc32_pkg::crc_variant_e VARIANT  = crc32_pkg::CRC_ISO_HDLC,
  parameter bit                      IN_REFL  = 1'b1,
  parameter bit                      OUT_REFL = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        wr_i,
  input  logic [31:0] data_i,
  output logic [31:0] view_o
);
  import crc32_pkg::*;

  localparam logic [CRC_W-1:0] POLY = poly_of(VARIANT);
  localparam logic [CRC_W-1:0] INIT = init_of(VARIANT);

  logic [CRC_W-1:0] state_q, word_in;

  generate
    if (IN_REFL) begin : g_in_refl
      assign word_in = reflect32(data_i);
    end else begin : g_in_plain
      assign word_in = data_i;
    end
    if (OUT_REFL) begin : g_out_refl
      assign view_o = reflect32(state_q);
    end else begin : g_out_plain
      assign view_o = state_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= INIT;
    else if (clr_i) state_q <= INIT;
    else if (wr_i)  state_q <= crc_fold(state_q, word_in, POLY);
  end

  p_restart_init_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (state_q == INIT));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !wr_i) |=> $stable(state_q));

endmodule

// File: rtl/crc32_xor_reg.sv
module crc32_xor_reg #(
  parameter bit          PRESENT   = 1'b0,
  parameter logic [31:0] RESET_VAL = 32'hFFFF_FFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] xor_o,
  output logic [31:0] rd_o
);
  generate
    if (PRESENT) begin : g_reg
      logic [31:0] xor_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   xor_q <= RESET_VAL;
        else if (we_i) xor_q <= wdata_i;
      end
      assign xor_o = xor_q;
      assign rd_o  = xor_q;

      p_xor_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(xor_q));
    end else begin : g_fixed
      logic unused_xor;
      assign unused_xor = ^{clk_i, rst_ni, we_i, wdata_i};
      assign xor_o = RESET_VAL;
      assign rd_o  = '0;
    end
  endgenerate

endmodule

// File: rtl/crc32_apb_accel.sv
module crc32_apb_accel #(
  parameter crc32_pkg::crc_variant_e VARIANT    = crc32_pkg::CRC_ISO_HDLC,
  parameter bit                      IN_REFL    = 1'b1,
  parameter bit                      OUT_REFL   = 1'b1,
  parameter bit                      XOR_REG_EN = 1'b0,
  parameter int unsigned             ADDR_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [31:0]       pwdata_i,
  output logic [31:0]       prdata_o,
  output logic              pready_o,
  output logic              pslverr_o
);
  import crc32_pkg::*;

  localparam logic [7:0]  ORDER    = 8'(CRC_W);
  localparam logic [31:0] INFO_VAL = {21'd0, XOR_REG_EN, OUT_REFL, IN_REFL, ORDER};

  logic        ctrl_we, data_we, xor_we;
  logic        rd_info, rd_result, rd_xor;
  logic [31:0] view, xor_val, xor_rd;

  crc32_apb_port #(.ADDR_W(ADDR_W)) i_port (
    .psel_i      (psel_i),
    .penable_i   (penable_i),
    .pwrite_i    (pwrite_i),
    .paddr_i     (paddr_i),
    .ctrl_we_o   (ctrl_we),
    .data_we_o   (data_we),
    .xor_we_o    (xor_we),
    .rd_info_o   (rd_info),
    .rd_result_o (rd_result),
    .rd_xor_o    (rd_xor),
    .pready_o    (pready_o),
    .pslverr_o   (pslverr_o)
  );

  crc32_engine #(.VARIANT(VARIANT), .IN_REFL(IN_REFL), .OUT_REFL(OUT_REFL)) i_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_we),
    .wr_i   (data_we),
    .data_i (pwdata_i),
    .view_o (view)
  );

  crc32_xor_reg #(.PRESENT(XOR_REG_EN), .RESET_VAL(xorout_of(VARIANT))) i_xor (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (xor_we),
    .wdata_i (pwdata_i),
    .xor_o   (xor_val),
    .rd_o    (xor_rd)
  );

  always_comb begin
    prdata_o = '0;
    if (rd_info)   prdata_o = INFO_VAL;
    if (rd_result) prdata_o = view ^ xor_val;
    if (rd_xor)    prdata_o = xor_rd;
  end

  p_info_layout_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && !pwrite_i && paddr_i == ADDR_W'(OFF_INFO)) |->
      (prdata_o[31:11] == '0 && prdata_o[7:0] == 8'd32 && prdata_o[8] == IN_REFL &&
       prdata_o[9] == OUT_REFL && prdata_o[10] == XOR_REG_EN));

  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && !pwrite_i && paddr_i != ADDR_W'(OFF_INFO) &&
     paddr_i != ADDR_W'(OFF_RESULT) && paddr_i != ADDR_W'(OFF_XOR)) |-> (prdata_o == '0));

  p_absent_xor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!XOR_REG_EN && psel_i && penable_i && !pwrite_i && paddr_i == ADDR_W'(OFF_XOR)) |->
      (prdata_o == '0));

endmodule

// File: tb/test_crc32_apb_accel.sv
module test_crc32_apb_accel;
  import crc32_pkg::*;

  localparam int NB = 3;
  localparam int MAX_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        psel[NB], penable[NB], pwrite[NB], pready[NB], pslverr[NB];
  logic [7:0]  paddr[NB];
  logic [31:0] pwdata[NB], prdata[NB];

  // 0: default build, 1: writable final XOR, 2: XFER without reflection
  crc32_apb_accel i_crc32_apb_accel (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel[0]), .penable_i(penable[0]),
    .pwrite_i(pwrite[0]), .paddr_i(paddr[0]), .pwdata_i(pwdata[0]),
    .prdata_o(prdata[0]), .pready_o(pready[0]), .pslverr_o(pslverr[0]));

  crc32_apb_accel #(.XOR_REG_EN(1'b1)) i_crc32_apb_accel_x (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel[1]), .penable_i(penable[1]),
    .pwrite_i(pwrite[1]), .paddr_i(paddr[1]), .pwdata_i(pwdata[1]),
    .prdata_o(prdata[1]), .pready_o(pready[1]), .pslverr_o(pslverr[1]));

  crc32_apb_accel #(.VARIANT(CRC_XFER), .IN_REFL(1'b0), .OUT_REFL(1'b0)) i_crc32_apb_accel_f (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel[2]), .penable_i(penable[2]),
    .pwrite_i(pwrite[2]), .paddr_i(paddr[2]), .pwdata_i(pwdata[2]),
    .prdata_o(prdata[2]), .pready_o(pready[2]), .pslverr_o(pslverr[2]));

  typedef struct {
    int          bus;
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // reference models, written byte-wise and independent of the RTL fold
  function automatic logic [31:0] iso_fold(logic [31:0] c, logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      c ^= {24'd0, w[8*b +: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] xfer_fold(logic [31:0] c, logic [31:0] w);
    for (int b = 3; b >= 0; b--) begin
      c ^= {w[8*b +: 8], 24'd0};
      for (int j = 0; j < 8; j++) c = c[31] ? ((c << 1) ^ 32'h0000_00AF) : (c << 1);
    end
    return c;
  endfunction

  task automatic apb_wr(input int k, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel[k] = 1'b1; pwrite[k] = 1'b1; paddr[k] = a; pwdata[k] = d; penable[k] = 1'b0;
    @(posedge clk); #1;
    penable[k] = 1'b1;
    @(posedge clk); #1;
    psel[k] = 1'b0; penable[k] = 1'b0; pwrite[k] = 1'b0;
  endtask

  task automatic apb_rd(input int k, input logic [7:0] a, input logic [31:0] e, input string req);
    sb_item_t it;
    it.bus = k; it.exp = e; it.req = req;
    sb_q.push_back(it);
    @(posedge clk); #1;
    psel[k] = 1'b1; pwrite[k] = 1'b0; paddr[k] = a; penable[k] = 1'b0;
    @(posedge clk); #1;
    penable[k] = 1'b1;
    @(posedge clk); #1;
    psel[k] = 1'b0; penable[k] = 1'b0;
  endtask

  // monitor: samples mid access phase, pops the scoreboard on reads
  initial begin
    forever begin
      @(negedge clk);
      for (int k = 0; k < NB; k++) begin
        if (rst_n && psel[k] && penable[k]) begin
          check(pready[k] === 1'b1 && pslverr[k] === 1'b0, "R1",
                {30'd0, pslverr[k], pready[k]}, 32'h1);
          if (!pwrite[k]) begin
            if (sb_q.size() == 0) begin
              check(1'b0, "R1 unexpected read", prdata[k], 32'h0);
            end else begin
              sb_item_t it;
              it = sb_q.pop_front();
              check(it.bus == k && prdata[k] === it.exp, it.req, prdata[k], it.exp);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    check(1'b0, "R1 watchdog", 32'(MAX_CYC), 32'h0);
    finish_run();
  end

  logic [31:0] words[6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
                            32'hDEAD_BEEF, 32'h8000_0001, 32'h0102_0304};

  initial begin
    logic [31:0] raw;
    for (int k = 0; k < NB; k++) begin
      psel[k] = 1'b0; penable[k] = 1'b0; pwrite[k] = 1'b0; paddr[k] = '0; pwdata[k] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state, R1 at ports
    @(negedge clk);
    check(pready[0] === 1'b1 && pslverr[0] === 1'b0, "R1 reset", {31'd0, pready[0]}, 32'h1);

    // default build
    apb_rd(0, OFF_RESULT, 32'h0000_0000, "R2 reset checksum");
    apb_rd(0, OFF_INFO, 32'h0000_0320, "R6 info default");
    apb_rd(0, OFF_XOR, 32'h0, "R8 absent xor reads 0");
    apb_rd(0, OFF_CTRL, 32'h0, "R9 restart reg reads 0");
    apb_rd(0, OFF_DATA, 32'h0, "R9 data reg reads 0");
    apb_rd(0, 8'h04, 32'h0, "R9 unmapped 0x04");
    apb_rd(0, 8'hFC, 32'h0, "R9 unmapped 0xFC");

    apb_wr(0, OFF_DATA, 32'h6463_6261);
    apb_rd(0, OFF_RESULT, 32'hED82_CD11, "R3 abcd word");
    apb_rd(0, OFF_RESULT, 32'hED82_CD11, "R3 state holds");
    apb_wr(0, OFF_XOR, 32'h0F0F_0F0F);
    apb_rd(0, OFF_XOR, 32'h0, "R8 xor write ignored");
    apb_rd(0, OFF_RESULT, 32'hED82_CD11, "R8 checksum unchanged");
    apb_wr(0, OFF_CTRL, 32'hA5A5_A5A5);
    apb_rd(0, OFF_RESULT, 32'h0, "R5 restart reload");

    raw = 32'hFFFF_FFFF;
    foreach (words[i]) begin
      apb_wr(0, OFF_DATA, words[i]);
      raw = iso_fold(raw, words[i]);
      apb_rd(0, OFF_RESULT, ~raw, "R4 stream");
    end
    apb_wr(0, OFF_CTRL, 32'h0);
    apb_rd(0, OFF_RESULT, 32'h0, "R5 restart with zero");

    // writable final XOR build
    apb_rd(1, OFF_INFO, 32'h0000_0720, "R6 info xor build");
    apb_rd(1, OFF_XOR, 32'hFFFF_FFFF, "R7 xor reset value");
    apb_rd(1, OFF_RESULT, 32'h0, "R2 xor build reset");
    raw = 32'hFFFF_FFFF;
    for (int i = 2; i < 5; i++) begin
      apb_wr(1, OFF_DATA, words[i]);
      raw = iso_fold(raw, words[i]);
    end
    apb_rd(1, OFF_RESULT, ~raw, "R7 default final xor");
    apb_wr(1, OFF_XOR, 32'h1234_5678);
    apb_rd(1, OFF_XOR, 32'h1234_5678, "R7 xor readback");
    apb_rd(1, OFF_RESULT, raw ^ 32'h1234_5678, "R7 custom final xor");
    apb_wr(1, OFF_CTRL, 32'h1);
    apb_rd(1, OFF_RESULT, 32'hFFFF_FFFF ^ 32'h1234_5678, "R5 restart xor build");

    // XFER, no reflection
    apb_rd(2, OFF_INFO, 32'h0000_0020, "R6 info xfer build");
    apb_rd(2, OFF_RESULT, 32'h0, "R10 xfer reset");
    raw = 32'h0;
    foreach (words[i]) begin
      apb_wr(2, OFF_DATA, words[i]);
      raw = xfer_fold(raw, words[i]);
      apb_rd(2, OFF_RESULT, raw, "R10 xfer stream");
    end

    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule